// File: doc/BRIEF.md
# Synthesizer Configuration Register

This block holds the divider and test-select word that sets up a clock synthesizer. The word can arrive in two ways. A serial path shifts bits in from a data pin on the rising edge of a shift clock, and copies the shift chain into the configuration store under a serial load strobe. A parallel path presents the loop divider and output divider values on pins, and copies them into the store under a parallel load strobe. The stored loop divider, output divider code and test-select field go to the rest of the synthesizer.

The two strobes work with opposite polarity. The serial store is open while its strobe is high and keeps the value it held at the falling edge. The parallel store is open while its strobe is low and keeps the value it held at the rising edge. The test-select field can only be written through the serial path.

All pins are asynchronous to the system clock. They pass through a synchronizer of `SYNC_STAGES` flops. Rising edges of the shift clock are detected in the system clock domain, and both level-sensitive stores are built as registers in that domain. While the inputs are in reset, the synchronizer holds each strobe and data pin at the level a floating pin would settle to.

Top module: `synth_cfg_reg`

## Requirements
- R1: During reset and after it, m_o, n_o and t_o are all zero.
- R2: Each rising edge of sclk_i shifts sdata_i into a 12-bit chain. A serial word is sent MSB first as t[2], t[1], t[0], n[1], n[0], m[6] down to m[0], so the last bit sent ends up in m_o[0].
- R3: While sload_i is high and pload_i is high, t_o, n_o and m_o follow the chain contents, including bits that are shifted in while the strobe stays high.
- R4: While sload_i is low and pload_i is high, shifting on sclk_i and sdata_i leaves all outputs unchanged.
- R5: While pload_i is low, m_o and n_o follow m_i and n_i.
- R6: While pload_i is high and sload_i is low, changes on m_i and n_i have no effect on the outputs.
- R7: The parallel path never changes t_o.
- R8: When both strobes are open at once, m_o and n_o take m_i and n_i, and t_o takes the test field of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sload_i | input | 1 | Serial load strobe, open while high |
| pload_i | input | 1 | Parallel load strobe, open while low |
| m_i | input | 7 | Parallel loop divider value, bit 6 is MSB |
| n_i | input | 2 | Parallel output divider code |
| m_o | output | 7 | Stored loop divider |
| n_o | output | 2 | Stored output divider code |
| t_o | output | 3 | Stored test-select field |

## Verification
The hardest case to reach is the overlap of both open windows. Here the divider fields must come from the pins while the test field still comes from the chain. The case after it is also hard: closing the parallel strobe while the serial one stays open, which has to hand the divider fields back to the chain. The stimulus first loads a known word into the chain with the serial strobe closed. It then opens both strobes with different parallel values and closes them one at a time. A second hard case is shifting bits while the serial strobe stays open. The stimulus adds three bits after a full word and expects the outputs to show the word shifted by three positions.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int unsigned M_W    = 7;
  localparam int unsigned N_W    = 2;
  localparam int unsigned T_W    = 3;
  localparam int unsigned WORD_W = T_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (shift_en_i) q_o <= {q_o[W-2:0], din_i};
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import synth_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sload_i,
  input  logic           pload_i,
  input  cfg_t           chain_i,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  output cfg_t           cfg_o
);
  cfg_t cfg_d;

  // parallel window (strobe low) wins the divider fields; T is serial only
  always_comb begin
    cfg_d = cfg_o;
    if (sload_i) cfg_d = chain_i;
    if (!pload_i) begin
      cfg_d.m = m_i;
      cfg_d.n = n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_o <= '0;
    else cfg_o <= cfg_d;
  end
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sload_i,
  input  logic           pload_i,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o
);
  localparam int unsigned IN_W = 4 + M_W + N_W;
  // reset levels match open-pin defaults: serial pins low, parallel pins high
  localparam logic [IN_W-1:0] IN_RST = {3'b000, 1'b1, {M_W{1'b1}}, {N_W{1'b1}}};

  logic [IN_W-1:0] in_s;
  logic            sclk_s, sdata_s, sload_s, pload_s;
  logic [M_W-1:0]  m_s;
  logic [N_W-1:0]  n_s;
  logic            sclk_q, sclk_rise;
  logic [WORD_W-1:0] chain;
  cfg_t            cfg_q;

  cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdata_i, sload_i, pload_i, m_i, n_i}),
    .q_o   (in_s)
  );

  assign {sclk_s, sdata_s, sload_s, pload_s, m_s, n_s} = in_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;

  cfg_shift #(.W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(sclk_rise),
    .din_i     (sdata_s),
    .q_o       (chain)
  );

  cfg_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sload_i(sload_s),
    .pload_i(pload_s),
    .chain_i(cfg_t'(chain)),
    .m_i    (m_s),
    .n_i    (n_s),
    .cfg_o  (cfg_q)
  );

  assign m_o = cfg_q.m;
  assign n_o = cfg_q.n;
  assign t_o = cfg_q.t;
endmodule

// File: rtl/synth_cfg_reg_chk.sv
module synth_cfg_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sclk_rise,
  input logic        sdata_s,
  input logic        sload_s,
  input logic        pload_s,
  input logic [6:0]  m_s,
  input logic [1:0]  n_s,
  input logic [11:0] chain,
  input logic [6:0]  m_o,
  input logic [1:0]  n_o,
  input logic [2:0]  t_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |=> (m_o == '0 && n_o == '0 && t_o == '0));

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> chain == {$past(chain[10:0]), $past(sdata_s)});

  // R2
  shift_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise |=> $stable(chain));

  // R3
  ser_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sload_s && pload_s) |=> {t_o, n_o, m_o} == $past(chain));

  // R4
  // R6
  closed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sload_s && pload_s) |=> $stable({t_o, n_o, m_o}));

  // R5
  par_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_s |=> (m_o == $past(m_s) && n_o == $past(n_s)));

  // R7
  t_serial_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sload_s |=> $stable(t_o));

  // R8
  both_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sload_s && !pload_s) |=> (t_o == $past(chain[11:9]) && m_o == $past(m_s)));
endmodule

bind synth_cfg_reg synth_cfg_reg_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_rise(sclk_rise),
  .sdata_s  (sdata_s),
  .sload_s  (sload_s),
  .pload_s  (pload_s),
  .m_s      (m_s),
  .n_s      (n_s),
  .chain    (chain),
  .m_o      (m_o),
  .n_o      (n_o),
  .t_o      (t_o)
);

// File: tb/synth_cfg_reg_bench.sv
module synth_cfg_reg_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b0, sdata_i = 1'b0, sload_i = 1'b0, pload_i = 1'b1;
  logic [6:0] m_i = 7'h7F, m_o;
  logic [1:0] n_i = 2'b11, n_o;
  logic [2:0] t_o;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic [11:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  ev_chk;

  always #4 clk_i = ~clk_i;

  synth_cfg_reg u_synth_cfg_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .sload_i(sload_i), .pload_i(pload_i), .m_i(m_i), .n_i(n_i),
    .m_o(m_o), .n_o(n_o), .t_o(t_o)
  );

  function automatic logic [11:0] word(input logic [2:0] t, input logic [1:0] n, input logic [6:0] m);
    return {t, n, m};
  endfunction

  // monitor: pop expected and compare outputs
  always @(ev_chk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if ({t_o, n_o, m_o} !== it.exp) begin
        bad++;
        $display("FAIL %s: got t=%0h n=%0h m=%0h exp t=%0h n=%0h m=%0h", it.tag,
                 t_o, n_o, m_o, it.exp[11:9], it.exp[8:7], it.exp[6:0]);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_now(input logic [11:0] e, input string tag);
    wait_clk(8);
    sb_q.push_back('{exp: e, tag: tag});
    -> ev_chk;
    wait_clk(1);
  endtask

  task automatic shift_bit(input logic b);
    sdata_i = b;
    wait_clk(4);
    sclk_i = 1'b1;
    wait_clk(4);
    sclk_i = 1'b0;
  endtask

  task automatic shift_word(input logic [11:0] w);
    for (int i = 11; i >= 0; i--) shift_bit(w[i]);
  endtask

  initial begin
    logic [11:0] wa, wb, wc, w3, cur;
    wa = word(3'd5, 2'd2, 7'h4B);
    wb = word(3'd2, 2'd1, 7'h35);
    wc = word(3'd6, 2'd3, 7'h0C);
    wait_clk(3);
    // R1 during reset
    expect_now(12'h000, "R1 in reset");
    rst_ni = 1'b1;
    expect_now(12'h000, "R1 after reset");

    // R2 full serial load
    shift_word(wa);
    sload_i = 1'b1;
    expect_now(wa, "R2 serial word");
    sload_i = 1'b0;
    expect_now(wa, "R2 hold after close");

    // R4 shifting with strobe closed
    shift_word(wb);
    expect_now(wa, "R4 shift ignored");

    // R3 transparent, then more bits while open
    sload_i = 1'b1;
    expect_now(wb, "R3 open shows chain");
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
    w3 = {wb[8:0], 3'b101};
    expect_now(w3, "R3 follows extra bits");
    sload_i = 1'b0;
    shift_word(wc);
    expect_now(w3, "R4 held after fall");

    // R5 parallel transparent, R7 t kept
    m_i = 7'h11; n_i = 2'd1; pload_i = 1'b0;
    cur = word(w3[11:9], 2'd1, 7'h11);
    expect_now(cur, "R5 parallel open R7");
    m_i = 7'h22; n_i = 2'd2;
    cur = word(w3[11:9], 2'd2, 7'h22);
    expect_now(cur, "R5 follows change R7");

    // R6 captured on rise
    pload_i = 1'b1;
    wait_clk(6);
    m_i = 7'h7F; n_i = 2'd3;
    expect_now(cur, "R6 change ignored");

    // R8 both open: dividers from pins, T from chain (wc)
    m_i = 7'h33; n_i = 2'd0;
    pload_i = 1'b0; sload_i = 1'b1;
    expect_now(word(wc[11:9], 2'd0, 7'h33), "R8 both open");
    pload_i = 1'b1;
    expect_now(wc, "R8 parallel closed, serial open");
    sload_i = 1'b0;

    // R2 bit order: single LSB, then all ones
    shift_word(word(3'd0, 2'd0, 7'h01));
    sload_i = 1'b1;
    expect_now(12'h001, "R2 m0 is last bit");
    sload_i = 1'b0;
    shift_word(word(3'd4, 2'd0, 7'h40));
    sload_i = 1'b1;
    expect_now(word(3'd4, 2'd0, 7'h40), "R2 first bits are t2 and m6");
    sload_i = 1'b0;
    shift_word(12'hFFF);
    sload_i = 1'b1;
    expect_now(12'hFFF, "R2 all ones");
    sload_i = 1'b0;

    wait_clk(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule